// File: doc/BRIEF.md
# Clock Divider Step Sequencer

This block moves a processor clock between the divide ratios 1, 2, 4, 6 and 8, and keeps the DRAM refresh interval correct while it does so. A requester hands it a ratio index. The block then works out the legal path to that ratio. It drives a 3-bit divider-mode field, which stands in for the PLL control, and a 7-bit refresh-count field, which stands in for the memory controller setting. It orders the two writes according to the direction of the change. It also inserts the PLL lock wait and the refresh drain wait.

A change between divide-by-1 and any ratio above 2 is split into two steps, with divide-by-2 in between. When the clock slows down, the refresh count is written before the divider. When the clock speeds up, the divider is written first. The refresh count for each ratio comes from a constant table that is computed at elaboration from the base clock frequency. The block runs on the base clock, so every wait is counted in base-clock cycles.

The request port is a valid/ready pair. `req_ready` is high only while the block is idle, and a transfer happens on a cycle where `req_valid` and `req_ready` are both high. A `req_valid` that is raised while `req_ready` is low is not stored or queued. It is simply not taken, so a sender that needs the change must hold `req_valid` until it sees `req_ready`. `busy` and `done` are plain status pins.

Top module: `cdiv_step_seq`

## Requirements
- R1: After reset, `div_mode` is 000 (divide-by-1), `refr_count` holds the divide-by-1 table value, `busy` and `done` are 0, and `req_ready` is 1.
- R2: Ratio indices 0, 1, 2, 3 and 4 select divide-by 1, 2, 4, 6 and 8. Their `div_mode` codes are 000, 001, 011, 010 and 100, and `div_mode` never holds any other value. When a request completes, `div_mode` carries the code of the requested index.
- R3: Every value written to `refr_count` is floor(BASE_CLK_HZ × WINDOW_NS / (64 × divisor × 10^9)) for the ratio being entered, saturated at 127. With a 100 MHz base clock and a 7800 ns window, the values for ratios 1, 2, 4, 6 and 8 are 12, 6, 3, 2 and 1.
- R4: `div_mode` never changes directly between 000 and any of 011, 010 or 100. Such a request passes through 001, with its own refresh update.
- R5: For each step to a larger divisor, `refr_count` changes first and `div_mode` changes after it. For each step to a smaller divisor, `div_mode` changes first and `refr_count` changes after it.
- R6: After any change of `div_mode`, at least LOCK_CYC (16) cycles pass before the next change of `div_mode` or `refr_count`.
- R7: On a step to a larger divisor with `selfref_en` low, at least 64 × (new count + old count) × old divisor cycles pass between the `refr_count` change and the `div_mode` change. With `selfref_en` high, this drain wait is skipped.
- R8: A request for the ratio that is already set makes no change to `div_mode` or `refr_count`, and still produces one `done` pulse.
- R9: An accepted request whose index is 5, 6 or 7 is dropped. `busy` stays low, and no output field changes.
- R10: `req_ready` is low whenever `busy` is high. A `req_valid` that is raised while `req_ready` is low has no effect on the transition in progress or after it.
- R11: `done` is high for exactly one cycle when the last step of a request finishes. In that cycle `busy` is already low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; all waits are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | High while idle; a request transfers on valid and ready |
| req_idx | input | 3 | Target ratio index, 0 to 4 legal |
| selfref_en | input | 1 | DRAM self-refresh enabled; when high, the drain wait is skipped |
| div_mode | output | 3 | Divider-mode field driven to the PLL |
| refr_count | output | 7 | Refresh-count field driven to the memory controller |
| busy | output | 1 | High while a request is being carried out |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The assertions assume three things about the inputs. `selfref_en` stays steady from the start of a transition until its refresh step has been taken. `req_idx` is meaningful only in the cycle of a transfer. Reset is applied before the first request. The bench changes `selfref_en` only while the block is idle, and it drives all inputs half a cycle away from the active edge. It sweeps every ordered pair of ratios with self-refresh both on and off, and it deliberately raises `req_valid` with a different index while a transition is running, so that the dropped-request rule is exercised rather than avoided.

// File: rtl/cdsq_pkg.sv
package cdsq_pkg;
  localparam int NUM_RATIOS = 5;
  localparam int IDX_W      = 3;
  localparam int CODE_W     = 3;
  localparam int DIV_W      = 4;

  typedef logic [IDX_W-1:0]  ratio_idx_t;
  typedef logic [CODE_W-1:0] div_code_t;
  typedef logic [DIV_W-1:0]  divisor_t;

  // Non-monotonic mode encoding driven to the PLL.
  function automatic div_code_t idx_to_code(input ratio_idx_t i);
    case (i)
      3'd0:    return 3'b000;
      3'd1:    return 3'b001;
      3'd2:    return 3'b011;
      3'd3:    return 3'b010;
      3'd4:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic ratio_idx_t code_to_idx(input div_code_t c);
    case (c)
      3'b000:  return 3'd0;
      3'b001:  return 3'd1;
      3'b011:  return 3'd2;
      3'b010:  return 3'd3;
      3'b100:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // Index 0 is divide-by-1, index n>0 is divide-by-2n.
  function automatic divisor_t idx_to_div(input ratio_idx_t i);
    return (i == 3'd0) ? 4'd1 : {i, 1'b0};
  endfunction
endpackage

// File: rtl/cdsq_refresh_table.sv
module cdsq_refresh_table
  import cdsq_pkg::*;
#(
  parameter longint BASE_CLK_HZ = 500_000_000,
  parameter longint WINDOW_NS   = 7800,
  parameter int     UNIT_CYC    = 64,
  parameter int     CNT_W       = 7
) (
  output logic [NUM_RATIOS-1:0][CNT_W-1:0] counts
);
  localparam longint NS_PER_S = 64'd1_000_000_000;
  localparam longint CNT_MAX  = (64'd1 << CNT_W) - 1;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_ratio
    localparam longint DIVV = (g == 0) ? 1 : 2 * g;
    localparam longint RAW  = (BASE_CLK_HZ * WINDOW_NS) /
                              (longint'(UNIT_CYC) * DIVV * NS_PER_S);
    localparam longint SAT  = (RAW > CNT_MAX) ? CNT_MAX : RAW;
    assign counts[g] = CNT_W'(SAT);
  end
endmodule

// File: rtl/cdsq_planner.sv
module cdsq_planner
  import cdsq_pkg::*;
(
  input  div_code_t  cur_code,
  input  ratio_idx_t tgt_idx,
  output ratio_idx_t cur_idx,
  output ratio_idx_t step_idx,
  output logic       step_slower,
  output logic       at_target
);
  divisor_t cur_div;
  divisor_t tgt_div;
  logic     via_two;

  always_comb begin
    cur_idx     = code_to_idx(cur_code);
    cur_div     = idx_to_div(cur_idx);
    tgt_div     = idx_to_div(tgt_idx);
    // Jumps between divide-by-1 and anything above 2 detour through 2.
    via_two     = ((cur_div == 4'd1) && (tgt_div > 4'd2)) ||
                  ((cur_div > 4'd2) && (tgt_div == 4'd1));
    step_idx    = via_two ? 3'd1 : tgt_idx;
    step_slower = idx_to_div(step_idx) > cur_div;
    at_target   = (cur_idx == tgt_idx);
  end
endmodule

// File: rtl/cdsq_wait_timer.sv
module cdsq_wait_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         idle
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/cdiv_step_seq.sv
module cdiv_step_seq
  import cdsq_pkg::*;
#(
  parameter longint BASE_CLK_HZ = 500_000_000,
  parameter longint WINDOW_NS   = 7800,
  parameter int     UNIT_CYC    = 64,
  parameter int     LOCK_CYC    = 16,
  parameter int     CNT_W       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_idx,
  input  logic             selfref_en,
  output logic [2:0]       div_mode,
  output logic [CNT_W-1:0] refr_count,
  output logic             busy,
  output logic             done
);
  localparam int DIV_MAX  = 8;
  localparam int WAIT_MAX = UNIT_CYC * 2 * ((1 << CNT_W) - 1) * DIV_MAX;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int GAP_W    = $clog2(LOCK_CYC + 1) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_REFR, S_DRAIN, S_DIV, S_LOCK
  } seq_state_t;

  seq_state_t state_q;
  ratio_idx_t tgt_q, step_q;
  logic       slow_q;

  logic [NUM_RATIOS-1:0][CNT_W-1:0] tbl;
  ratio_idx_t cur_idx, nxt_step;
  logic       nxt_slow, at_target;
  divisor_t   cur_div;
  logic              tmr_load, tmr_idle;
  logic [WAIT_W-1:0] tmr_val, drain_val;
  logic              accept;

  cdsq_refresh_table #(
    .BASE_CLK_HZ (BASE_CLK_HZ),
    .WINDOW_NS   (WINDOW_NS),
    .UNIT_CYC    (UNIT_CYC),
    .CNT_W       (CNT_W)
  ) u_table (
    .counts (tbl)
  );

  cdsq_planner u_plan (
    .cur_code    (div_mode),
    .tgt_idx     (tgt_q),
    .cur_idx     (cur_idx),
    .step_idx    (nxt_step),
    .step_slower (nxt_slow),
    .at_target   (at_target)
  );

  cdsq_wait_timer #(.W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .idle     (tmr_idle)
  );

  assign req_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign accept    = req_valid && req_ready;
  assign cur_div   = idx_to_div(cur_idx);

  // Drain: both the old and the new count must run out at the old rate.
  assign drain_val = WAIT_W'(UNIT_CYC) *
                     (WAIT_W'(tbl[step_q]) + WAIT_W'(refr_count)) *
                     WAIT_W'(cur_div);

  assign tmr_load = ((state_q == S_REFR) && slow_q && !selfref_en) ||
                    (state_q == S_DIV);
  assign tmr_val  = (state_q == S_DIV) ? WAIT_W'(LOCK_CYC) : drain_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      tgt_q      <= '0;
      step_q     <= '0;
      slow_q     <= 1'b0;
      div_mode   <= idx_to_code(3'd0);
      refr_count <= tbl[0];
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (accept && (req_idx < IDX_W'(NUM_RATIOS))) begin
            tgt_q   <= req_idx;
            state_q <= S_PLAN;
          end
        end
        S_PLAN: begin
          if (at_target) begin
            done    <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            step_q  <= nxt_step;
            slow_q  <= nxt_slow;
            state_q <= nxt_slow ? S_REFR : S_DIV;
          end
        end
        S_REFR: begin
          refr_count <= tbl[step_q];
          if (!slow_q)          state_q <= S_PLAN;
          else if (!selfref_en) state_q <= S_DRAIN;
          else                  state_q <= S_DIV;
        end
        S_DRAIN: begin
          if (tmr_idle) state_q <= S_DIV;
        end
        S_DIV: begin
          div_mode <= idx_to_code(step_q);
          state_q  <= S_LOCK;
        end
        S_LOCK: begin
          if (tmr_idle) state_q <= slow_q ? S_PLAN : S_REFR;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Checker state: cycles since the divider field last moved.
  logic [2:0]       div_prev_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_prev_q <= 3'b000;
      gap_q      <= GAP_W'(LOCK_CYC);
    end else begin
      div_prev_q <= div_mode;
      if (div_mode != div_prev_q)         gap_q <= GAP_W'(1);
      else if (gap_q < GAP_W'(LOCK_CYC))  gap_q <= gap_q + 1'b1;
    end
  end

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_mode inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100});

  // R4
  no_direct_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_mode) |->
      !((($past(div_mode) == 3'b000) && (div_mode inside {3'b011, 3'b010, 3'b100})) ||
        ((div_mode == 3'b000) && ($past(div_mode) inside {3'b011, 3'b010, 3'b100}))));

  // R5
  slow_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_mode) && (code_to_idx(div_mode) > code_to_idx($past(div_mode))))
      |-> (refr_count == tbl[code_to_idx(div_mode)]));

  // R5
  fast_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_mode) && (code_to_idx(div_mode) < code_to_idx($past(div_mode))))
      |-> (refr_count == tbl[code_to_idx($past(div_mode))]));

  // R6
  lock_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_mode) || !$stable(refr_count)) |-> (gap_q >= GAP_W'(LOCK_CYC)));

  // R9
  bad_idx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && (req_idx > 3'd4)) |=> !busy);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(tgt_q));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tb_cdiv_step_seq.sv
`timescale 1ns/1ps
module tb_cdiv_step_seq;
  localparam longint BASE = 100_000_000;
  localparam int     LOCK = 16;
  localparam int     EVMAX = 2048;
  localparam int     K_D = 1;
  localparam int     K_R = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_idx = 3'd0;
  logic       selfref_en = 1'b1;
  logic [2:0] div_mode;
  logic [6:0] refr_count;
  logic       busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cdiv_step_seq #(
    .BASE_CLK_HZ (BASE),
    .WINDOW_NS   (7800),
    .UNIT_CYC    (64),
    .LOCK_CYC    (LOCK),
    .CNT_W       (7)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_idx    (req_idx),
    .selfref_en (selfref_en),
    .div_mode   (div_mode),
    .refr_count (refr_count),
    .busy       (busy),
    .done       (done)
  );

  // Event log of output field changes, sampled at the falling edge.
  int ev_k [EVMAX];
  int ev_v [EVMAX];
  int ev_t [EVMAX];
  int ev_n = 0;
  int done_n = 0;
  logic [2:0] last_d = 3'b000;
  logic [6:0] last_r = 7'd0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (div_mode !== last_d && ev_n < EVMAX) begin
        ev_k[ev_n] = K_D; ev_v[ev_n] = int'(div_mode); ev_t[ev_n] = cyc; ev_n++;
      end
      if (refr_count !== last_r && ev_n < EVMAX) begin
        ev_k[ev_n] = K_R; ev_v[ev_n] = int'(refr_count); ev_t[ev_n] = cyc; ev_n++;
      end
      if (done) done_n++;
    end
    last_d = div_mode;
    last_r = refr_count;
  end

  function automatic int e_div(input int i);
    return (i == 0) ? 1 : 2 * i;
  endfunction

  function automatic int e_code(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 3;
      3: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int e_cnt(input int i);
    longint q;
    q = (BASE * 64'd7800) / (64'd64 * longint'(e_div(i)) * 64'd1_000_000_000);
    if (q > 127) q = 127;
    return int'(q);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic request(input int idx);
    @(negedge clk);
    req_valid = 1'b1;
    req_idx   = 3'(idx);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 1'b0;
    while (n < 20000 && !ok) begin
      @(negedge clk);
      if (done) ok = 1'b1;
      n++;
    end
  endtask

  task automatic run_pair(input int from, input int to, input bit sr);
    bit ok;
    int base, dbase, ne, c, s, act_n, gap;
    int xk [8];
    int xv [8];
    int xm [8];
    int xd [8];
    selfref_en = 1'b1;
    request(from);
    wait_done(ok);
    chk(ok, "R11", "setup done seen", int'(ok), 1);
    repeat (2) @(negedge clk);
    selfref_en = sr;
    base  = ev_n;
    dbase = done_n;
    request(to);
    wait_done(ok);
    chk(ok, "R11", "done seen", int'(ok), 1);
    chk(busy == 1'b0, "R11", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", int'(done), 0);
    chk(done_n - dbase == 1, "R11", "done pulse count", done_n - dbase, 1);

    // Expected step list from the requirements.
    ne = 0;
    c  = from;
    while (c != to) begin
      s = ((c == 0 && to >= 2) || (c >= 2 && to == 0)) ? 1 : to;
      if (s > c) begin
        xk[ne] = K_R; xv[ne] = e_cnt(s); xm[ne] = sr ? 2 : 1;
        xd[ne] = 64 * (e_cnt(s) + e_cnt(c)) * e_div(c); ne++;
        xk[ne] = K_D; xv[ne] = e_code(s); xm[ne] = 3; xd[ne] = 0; ne++;
      end else begin
        xk[ne] = K_D; xv[ne] = e_code(s); xm[ne] = 3; xd[ne] = 0; ne++;
        xk[ne] = K_R; xv[ne] = e_cnt(s); xm[ne] = 0; xd[ne] = 0; ne++;
      end
      c = s;
    end

    act_n = ev_n - base;
    if (from == to)
      chk(act_n == 0, "R8", "no field change on same ratio", act_n, 0);
    else
      chk(act_n == ne, "R4", "number of field writes", act_n, ne);
    for (int i = 0; i < ne && i < act_n; i++) begin
      chk(ev_k[base+i] == xk[i], "R5", "write order kind", ev_k[base+i], xk[i]);
      if (xk[i] == K_D)
        chk(ev_v[base+i] == xv[i], "R2", "divider code", ev_v[base+i], xv[i]);
      else
        chk(ev_v[base+i] == xv[i], "R3", "refresh count", ev_v[base+i], xv[i]);
      if (i + 1 < ne && i + 1 < act_n) begin
        gap = ev_t[base+i+1] - ev_t[base+i];
        if (xm[i] == 3) chk(gap >= LOCK, "R6", "lock gap", gap, LOCK);
        if (xm[i] == 1) chk(gap >= xd[i], "R7", "drain gap", gap, xd[i]);
        if (xm[i] == 2) chk(gap < xd[i], "R7", "no drain with self-refresh", gap, xd[i]);
      end
    end
    chk(int'(div_mode) == e_code(to), "R2", "final code", int'(div_mode), e_code(to));
    chk(int'(refr_count) == e_cnt(to), "R3", "final count", int'(refr_count), e_cnt(to));
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired: actual=%0d expected=%0d", cyc, 199000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    int base, dbase, busyc, nd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(div_mode == 3'b000, "R1", "reset code", int'(div_mode), 0);
    chk(int'(refr_count) == e_cnt(0), "R1", "reset count", int'(refr_count), e_cnt(0));
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);

    // Every ordered pair, with self-refresh off and on.
    for (int f = 0; f < 5; f++)
      for (int t = 0; t < 5; t++)
        for (int sr = 0; sr < 2; sr++)
          run_pair(f, t, sr[0]);

    // R9 out-of-range indices are dropped.
    for (int bad = 5; bad < 8; bad++) begin
      base  = ev_n;
      dbase = done_n;
      busyc = 0;
      request(bad);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (busy) busyc++;
      end
      chk(busyc == 0, "R9", "busy on bad index", busyc, 0);
      chk(ev_n == base, "R9", "field writes on bad index", ev_n - base, 0);
      chk(done_n == dbase, "R9", "done on bad index", done_n - dbase, 0);
    end

    // R10 request while busy is ignored.
    selfref_en = 1'b1;
    request(0);
    wait_done(ok);
    selfref_en = 1'b0;
    request(4);
    repeat (10) @(negedge clk);
    chk(req_ready == 1'b0, "R10", "ready low while busy", int'(req_ready), 0);
    chk(busy == 1'b1, "R10", "busy during transition", int'(busy), 1);
    req_valid = 1'b1;
    req_idx   = 3'd1;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    wait_done(ok);
    chk(ok, "R10", "transition completes", int'(ok), 1);
    nd = ev_n;
    chk(int'(div_mode) == e_code(4), "R10", "target kept", int'(div_mode), e_code(4));
    repeat (200) @(negedge clk);
    chk(ev_n == nd, "R10", "no late writes", ev_n - nd, 0);
    chk(int'(refr_count) == e_cnt(4), "R10", "count kept", int'(refr_count), e_cnt(4));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule